// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five interrupt sources and a processor core. The sources are external line 0, timer 0, external line 1, timer 1 and the serial port. Each request passes through a global enable and a per-source enable. The surviving requests are then sorted into two priority levels, chosen by software. Within a level a fixed order breaks ties. When a request wins, the block raises a one-cycle acknowledge to the core. The acknowledge carries the 16-bit entry address of the service routine and the index of the winning source.

A small service-level state machine records what is in service. Its states are `SVC_IDLE` (nothing), `SVC_LOW` (a low-level routine), `SVC_HIGH` (a high-level routine entered from idle) and `SVC_NEST` (a high-level routine preempting a low-level one). The transitions are:
- `SVC_IDLE` goes to `SVC_HIGH` on a high grant, or to `SVC_LOW` on a low grant.
- `SVC_LOW` goes to `SVC_NEST` on a high grant, or to `SVC_IDLE` on a return pulse.
- `SVC_HIGH` goes to `SVC_IDLE` on a return pulse.
- `SVC_NEST` goes to `SVC_LOW` on a return pulse.

A return pulse from the core therefore always closes the innermost active level.

Timer overflow requests arrive as one-cycle pulses. They are latched inside the block until the routine is entered, and are then cleared automatically. The external and serial requests are levels held by their owners. Two byte-wide registers, enable and priority, are written and read through a simple select/strobe port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable and priority registers read 0x00 and `ack_o` is low.
- R2: Writes happen at a clock edge when `wr_en_i` is high. `reg_sel_i`=0 selects the enable register, and all 8 bits read back as written. `reg_sel_i`=1 selects the priority register: bits 4:0 are stored and bits 7:5 read as zero. `rd_data_o` reflects the selected register combinationally.
- R3: A request is eligible only if enable bit 7 (global) is set and enable bit i is set for source index i.
- R4: Source indices are: 0 external line 0, 1 timer 0, 2 external line 1, 3 timer 1, 4 serial. With an acknowledge, `src_idx_o` gives the index and `vector_o` equals 0x0003 + 8*index (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R5: Among eligible requests on the same level, the lowest index wins.
- R6: Priority bit i set puts source i on the high level. Any eligible high-level request wins over every low-level request, whatever their indices.
- R7: A high-level request is granted only in `SVC_IDLE` or `SVC_LOW`. A low-level request is granted only in `SVC_IDLE`.
- R8: A return pulse on `reti_i` ends the innermost service (`SVC_NEST` to `SVC_LOW`; `SVC_LOW` or `SVC_HIGH` to `SVC_IDLE`). No grant is made at the edge where `reti_i` is high, so a waiting request is granted at the following edge.
- R9: Flag bits 1 and 3 (timers) are pulses latched at a clock edge and held until that source is acknowledged. Because of the latch, they are granted one edge after the pulse edge. Vectoring to a timer clears its latch, unless a new pulse arrives at the same edge.
- R10: Flag bits 0, 2 and 4 are levels sampled at each edge. A level dropped before the block is enabled leaves nothing pending.
- R11: `ack_o` is high for exactly one cycle after the edge at which the grant is made. It does not repeat while the granted level stays in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 priority |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Selected register read data |
| flag_i | input | 5 | Request flags by source index (timers as pulses) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| ack_o | output | 1 | One-cycle grant acknowledge |
| vector_o | output | 16 | Routine entry address, valid with ack_o |
| src_idx_o | output | 3 | Granted source index, valid with ack_o |

## Verification
The assertions assume that `reti_i` is a single-cycle pulse and that every input changes away from the rising clock edge. They also assume that a timer flag is a pulse, not a held level, so that the rule about clearing its latch can be observed. The bench drives all inputs at falling edges and pulses the timer bits for one cycle. It issues return pulses mainly to close a routine it has been granted; a return pulse in the idle state is harmless by R8 and is used only to drain the block between sweep trials. Before global enable is raised, every sweep trial sets up its pending flags with global enable off. This makes the first possible grant fall on a known edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Service-level state: which priority levels are currently in service.
    typedef enum logic [1:0] {
        SVC_IDLE = 2'b00,
        SVC_LOW  = 2'b01,
        SVC_HIGH = 2'b10,
        SVC_NEST = 2'b11
    } svc_state_e;

    // Register select codes for the byte-wide configuration port.
    localparam logic SEL_ENABLE   = 1'b0;
    localparam logic SEL_PRIORITY = 1'b1;

    // Number of priority levels handled by the picker array.
    localparam int unsigned NUM_LVL = 2;
    localparam int unsigned LVL_LOW  = 0;
    localparam int unsigned LVL_HIGH = 1;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned GE_BIT  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               reg_sel_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               glob_en_o,
    output logic [NUM_SRC-1:0] src_en_o,
    output logic [NUM_SRC-1:0] hi_lvl_o
);

    localparam int unsigned PAD_W = REG_W - NUM_SRC;

    logic [REG_W-1:0]   en_q;
    logic [NUM_SRC-1:0] prio_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
        end else if (wr_en_i) begin
            if (reg_sel_i == SEL_ENABLE) begin
                en_q <= wr_data_i;
            end else begin
                prio_q <= wr_data_i[NUM_SRC-1:0];
            end
        end
    end

    always_comb begin
        if (reg_sel_i == SEL_ENABLE) begin
            rd_data_o = en_q;
        end else begin
            rd_data_o = {{PAD_W{1'b0}}, prio_q};
        end
    end

    assign glob_en_o = en_q[GE_BIT];
    assign src_en_o  = en_q[NUM_SRC-1:0];
    assign hi_lvl_o  = prio_q;

endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch #(
    parameter int unsigned      NUM_SRC    = 5,
    parameter logic [NUM_SRC-1:0] LATCH_MASK = 5'b01010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (LATCH_MASK[i]) begin : g_latch
            logic flag_q;
            // A new pulse wins over the clear issued by a grant at the same edge.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (flag_i[i]) begin
                    flag_q <= 1'b1;
                end else if (clr_i[i]) begin
                    flag_q <= 1'b0;
                end
            end
            assign pend_o[i] = flag_q;
        end else begin : g_level
            logic unused_clr;
            assign unused_clr = clr_i[i];
            assign pend_o[i]  = flag_i[i];
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] cand_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_svc_fsm.sv
module irq_svc_fsm
    import irq_prio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_found_i,
    input  logic       lo_found_i,
    input  logic       reti_i,
    output logic       take_hi_o,
    output logic       take_lo_o,
    output svc_state_e state_o
);

    svc_state_e state_q;
    svc_state_e state_d;
    logic       allow_hi;
    logic       allow_lo;

    // A return pulse suppresses any grant at the same edge.
    always_comb begin
        allow_hi  = (state_q == SVC_IDLE) || (state_q == SVC_LOW);
        allow_lo  = (state_q == SVC_IDLE);
        take_hi_o = !reti_i && hi_found_i && allow_hi;
        take_lo_o = !reti_i && !hi_found_i && lo_found_i && allow_lo;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: begin
                if (take_hi_o) begin
                    state_d = SVC_HIGH;
                end else if (take_lo_o) begin
                    state_d = SVC_LOW;
                end
            end
            SVC_LOW: begin
                if (reti_i) begin
                    state_d = SVC_IDLE;
                end else if (take_hi_o) begin
                    state_d = SVC_NEST;
                end
            end
            SVC_HIGH: begin
                if (reti_i) begin
                    state_d = SVC_IDLE;
                end
            end
            SVC_NEST: begin
                if (reti_i) begin
                    state_d = SVC_LOW;
                end
            end
            default: state_d = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = 5,
    parameter int unsigned        REG_W      = 8,
    parameter int unsigned        GE_BIT     = 7,
    parameter int unsigned        VEC_W      = 16,
    parameter logic [15:0]        VEC_BASE   = 16'h0003,
    parameter logic [15:0]        VEC_STRIDE = 16'h0008,
    parameter logic [NUM_SRC-1:0] LATCH_MASK = 5'b01010,
    localparam int unsigned       IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               reg_sel_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic               reti_i,
    output logic               ack_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic [IDX_W-1:0]   src_idx_o
);

    logic               glob_en;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] hi_lvl;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant_clr;
    logic [NUM_SRC-1:0] cand  [NUM_LVL];
    logic               found [NUM_LVL];
    logic [IDX_W-1:0]   idx   [NUM_LVL];
    logic               take_hi;
    logic               take_lo;
    logic               take_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [VEC_W-1:0]   vec_next;
    svc_state_e         svc_state;

    logic               ack_q;
    logic [VEC_W-1:0]   vec_q;
    logic [IDX_W-1:0]   idx_q;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .REG_W   (REG_W),
        .GE_BIT  (GE_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .reg_sel_i (reg_sel_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .glob_en_o (glob_en),
        .src_en_o  (src_en),
        .hi_lvl_o  (hi_lvl)
    );

    irq_flag_latch #(
        .NUM_SRC    (NUM_SRC),
        .LATCH_MASK (LATCH_MASK)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_i),
        .clr_i  (grant_clr),
        .pend_o (pend)
    );

    assign elig                = glob_en ? (pend & src_en) : '0;
    assign cand[LVL_HIGH]      = elig & hi_lvl;
    assign cand[LVL_LOW]       = elig & ~hi_lvl;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        irq_pick #(
            .NUM_SRC (NUM_SRC),
            .IDX_W   (IDX_W)
        ) u_pick (
            .cand_i  (cand[l]),
            .found_o (found[l]),
            .idx_o   (idx[l])
        );
    end

    irq_svc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_found_i (found[LVL_HIGH]),
        .lo_found_i (found[LVL_LOW]),
        .reti_i     (reti_i),
        .take_hi_o  (take_hi),
        .take_lo_o  (take_lo),
        .state_o    (svc_state)
    );

    assign take_any  = take_hi || take_lo;
    assign pick_idx  = take_hi ? idx[LVL_HIGH] : idx[LVL_LOW];
    assign vec_next  = VEC_W'(VEC_BASE) + (VEC_W'(pick_idx) * VEC_W'(VEC_STRIDE));
    assign grant_clr = take_any ? (NUM_SRC'(1) << pick_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            vec_q <= '0;
            idx_q <= '0;
        end else begin
            ack_q <= take_any;
            if (take_any) begin
                vec_q <= vec_next;
                idx_q <= pick_idx;
            end
        end
    end

    assign ack_o     = ack_q;
    assign vector_o  = vec_q;
    assign src_idx_o = idx_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = 5,
    parameter logic [NUM_SRC-1:0] LATCH_MASK = 5'b01010,
    localparam int unsigned       IDX_W      = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_sel_i,
    input logic [7:0]         rd_data_o,
    input logic [NUM_SRC-1:0] flag_i,
    input logic               reti_i,
    input logic               ack_o,
    input logic [IDX_W-1:0]   src_idx_o,
    input logic               glob_en,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] hi_lvl,
    input logic [NUM_SRC-1:0] pend,
    input svc_state_e         svc_state
);

    logic [NUM_SRC-1:0] idx_oh;
    assign idx_oh = NUM_SRC'(1) << src_idx_o;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == SEL_PRIORITY) |-> (rd_data_o[7:5] == 3'b000));

    p_ack_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(glob_en));

    p_ack_src_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (($past(src_en) & idx_oh) != '0));

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (32'(src_idx_o) < NUM_SRC));

    p_low_loses_to_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (($past(hi_lvl) & idx_oh) == '0)) |-> $past((pend & src_en & hi_lvl) == '0));

    p_low_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (($past(hi_lvl) & idx_oh) == '0)) |-> ($past(svc_state) == SVC_IDLE));

    p_no_high_over_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(svc_state) == SVC_IDLE || $past(svc_state) == SVC_LOW));

    p_no_grant_on_reti_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !ack_o);

    p_reti_pops_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && svc_state == SVC_NEST) |=> (svc_state == SVC_LOW));

    p_timer_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && ((idx_oh & LATCH_MASK) != '0) && (($past(flag_i) & idx_oh) == '0))
            |-> ((pend & idx_oh) == '0));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC    (NUM_SRC),
    .LATCH_MASK (LATCH_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel_i (reg_sel_i),
    .rd_data_o (rd_data_o),
    .flag_i    (flag_i),
    .reti_i    (reti_i),
    .ack_o     (ack_o),
    .src_idx_o (src_idx_o),
    .glob_en   (glob_en),
    .src_en    (src_en),
    .hi_lvl    (hi_lvl),
    .pend      (pend),
    .svc_state (svc_state)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [7:0]  wr_data_i = '0;
    logic [7:0]  rd_data_o;
    logic [4:0]  flag_i = '0;
    logic        reti_i = 1'b0;
    logic        ack_o;
    logic [15:0] vector_o;
    logic [2:0]  src_idx_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .reg_sel_i (reg_sel_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .flag_i    (flag_i),
        .reti_i    (reti_i),
        .ack_o     (ack_o),
        .vector_o  (vector_o),
        .src_idx_o (src_idx_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        wr_en_i = 1'b1; reg_sel_i = sel; wr_data_i = data;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] data);
        reg_sel_i = sel;
        #1;
        data = rd_data_o;
    endtask

    task automatic ret_pulse();
        reti_i = 1'b1;
        tick();
        reti_i = 1'b0;
    endtask

    // Expected winner from the requirements: -1 means no grant.
    function automatic int exp_pick(input logic [4:0] pend, input logic [7:0] en,
                                    input logic [4:0] pr);
        logic [4:0] c;
        c = en[7] ? (pend & en[4:0]) : 5'b0;
        for (int i = 0; i < 5; i++) if (c[i] && pr[i]) return i;
        for (int i = 0; i < 5; i++) if (c[i] && !pr[i]) return i;
        return -1;
    endfunction

    task automatic drain();
        flag_i = '0;
        wr(1'b0, 8'h9F);
        wr(1'b1, 8'h00);
        for (int k = 0; k < 4; k++) begin
            ret_pulse();
            tick();
            tick();
        end
        wr(1'b0, 8'h00);
    endtask

    task automatic trial(input string req, input logic [7:0] en, input logic [4:0] pr,
                         input logic [4:0] pat);
        int e;
        wr(1'b0, en & 8'h1F);
        wr(1'b1, {3'b000, pr});
        flag_i = pat;
        tick();
        flag_i = pat & 5'b10101;
        wr(1'b0, en);
        tick();
        e = exp_pick(pat, en, pr);
        chk(req, 32'(ack_o), 32'(e >= 0));
        if (e >= 0) begin
            chk("R4 index", 32'(src_idx_o), 32'(e));
            chk("R4 vector", 32'(vector_o), 32'(3 + 8 * e));
        end
        tick();
        chk("R11 single pulse", 32'(ack_o), 32'd0);
        drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(1'b0, d); chk("R1 enable reset", 32'(d), 32'h00);
        rd(1'b1, d); chk("R1 priority reset", 32'(d), 32'h00);
        chk("R1 ack reset", 32'(ack_o), 32'd0);

        // R2 register access
        wr(1'b0, 8'hA5); rd(1'b0, d); chk("R2 enable readback", 32'(d), 32'hA5);
        wr(1'b1, 8'hFF); rd(1'b1, d); chk("R2 priority reserved zero", 32'(d), 32'h1F);
        wr(1'b1, 8'h0A); rd(1'b1, d); chk("R2 priority readback", 32'(d), 32'h0A);
        wr(1'b1, 8'h00); wr(1'b0, 8'h00);
        rd(1'b0, d); chk("R2 enable cleared", 32'(d), 32'h00);

        // R10 level source dropped while disabled leaves nothing pending
        flag_i = 5'b00001;
        tick();
        flag_i = '0;
        wr(1'b0, 8'h9F);
        tick(); chk("R10 level not latched", 32'(ack_o), 32'd0);
        tick(); chk("R10 level not latched later", 32'(ack_o), 32'd0);
        wr(1'b0, 8'h00);

        // R9 timer pulse while disabled is latched and granted later
        flag_i = 5'b00010;
        tick();
        flag_i = '0;
        wr(1'b0, 8'h9F);
        tick();
        chk("R9 latched timer ack", 32'(ack_o), 32'd1);
        chk("R9 latched timer index", 32'(src_idx_o), 32'd1);
        chk("R9 timer vector", 32'(vector_o), 32'h000B);
        ret_pulse();
        tick(); chk("R9 timer flag cleared", 32'(ack_o), 32'd0);
        tick(); chk("R9 timer flag cleared later", 32'(ack_o), 32'd0);

        // R7 / R8 nesting sequence: external 1 and timer 1 on high level
        wr(1'b1, 8'h0C);
        flag_i = 5'b00001;
        tick();
        chk("R7 low grant from idle", 32'(ack_o), 32'd1);
        chk("R4 ext0 vector", 32'(vector_o), 32'h0003);
        flag_i = 5'b00100;
        tick();
        chk("R7 high preempts low", 32'(ack_o), 32'd1);
        chk("R4 ext1 vector", 32'(vector_o), 32'h0013);
        flag_i = 5'b01000;
        tick();
        flag_i = '0;
        chk("R7 no high over high a", 32'(ack_o), 32'd0);
        tick(); chk("R7 no high over high b", 32'(ack_o), 32'd0);
        tick(); chk("R7 no high over high c", 32'(ack_o), 32'd0);
        ret_pulse();
        chk("R8 no grant at return edge", 32'(ack_o), 32'd0);
        tick();
        chk("R8 pending high after return", 32'(ack_o), 32'd1);
        chk("R8 timer1 index", 32'(src_idx_o), 32'd3);
        chk("R4 timer1 vector", 32'(vector_o), 32'h001B);
        flag_i = 5'b10000;
        ret_pulse();
        chk("R8 return to low", 32'(ack_o), 32'd0);
        tick(); chk("R7 low waits while low in service", 32'(ack_o), 32'd0);
        tick(); chk("R7 low still waits", 32'(ack_o), 32'd0);
        ret_pulse();
        chk("R8 return to idle", 32'(ack_o), 32'd0);
        tick();
        chk("R8 waiting low taken", 32'(ack_o), 32'd1);
        chk("R4 serial vector", 32'(vector_o), 32'h0023);
        flag_i = '0;
        ret_pulse();
        tick(); chk("R9 no regrant of cleared timer", 32'(ack_o), 32'd0);
        tick(); chk("R9 no regrant later", 32'(ack_o), 32'd0);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);

        // R3 sweep: global bit and every per-source enable against every pattern
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < 32; s++)
                for (int p = 0; p < 32; p++)
                    trial("R3 enable masking", {g[0], 2'b00, s[4:0]}, 5'b10010, p[4:0]);

        // R5 / R6 sweep: every priority setting against every pattern
        for (int q = 0; q < 32; q++)
            for (int p = 0; p < 32; p++)
                trial("R5 R6 level and order", 8'h9F, q[4:0], p[4:0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule